// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits next to a processor core and arbitrates among the interrupt vectors that other agents deliver to that core. It keeps three bit maps over the vector space: requested, in-service and trigger-mode. From these and a task priority value it derives the processor priority. It raises an interrupt line whenever the best pending vector belongs to a higher 16-vector class than that priority.

The core takes a vector with a one-cycle acknowledge handshake and retires it with an end-of-interrupt register write. Software sets the task priority through the register port. The core can also load a 4-bit class value straight into it. A 9-bit spurious register holds the software enable bit and the vector that is handed out when an acknowledge is refused. A reset or an initialisation pulse brings the unit back to a software-disabled, empty state.

Top module: `irq_prio_unit`

## Requirements
- R1: An accept strobe sets the request bit of the given vector. In the same edge it sets that vector's trigger bit when the level flag is 1 and clears it when the flag is 0.
- R2: The register port reads all three maps as 32-bit words. The address is {group[1:0], word[2:0]}, with group 1 for request, 2 for in-service and 3 for trigger. Bit j of word k is vector 32k+j.
- R3: The highest-priority vector of a map is its highest-numbered set bit.
- R4: The interrupt output is low whenever bit 8 of the spurious register (software enable) is 0.
- R5: With the unit enabled and a request pending, the interrupt output is high exactly when the processor priority is 0 or the top request's bits 7:4 exceed the processor priority's bits 7:4.
- R6: An acknowledge request is answered one cycle later with ackValid and a vector, and it clears the top request bit. If the task priority is nonzero and the top request is at or below it, the vector returned is bits 7:0 of the spurious register and no in-service bit is set. If no request is pending, the same spurious vector is returned. Otherwise the top request's in-service bit is set and that vector is returned.
- R7: The processor priority reads at scalar word 1. It equals the task priority when no vector is in service or when the task priority's bits 7:4 are at least the top in-service vector's bits 7:4. Otherwise it equals the top in-service vector with bits 3:0 cleared.
- R8: A write to scalar word 3 (end of interrupt) clears the highest in-service bit. With nothing in service it changes nothing.
- R9: A core task-priority load stores the 4-bit value in bits 7:4 and zeroes bits 3:0. It wins over a register write to scalar word 0 in the same cycle.
- R10: Reset or initReq clears all three maps and the task priority, sets the spurious register to 0x0FF and drops ackValid.
- R11: If an accept and an acknowledge name the same vector in one cycle, the request bit stays set. If an end of interrupt and an acknowledge fall in one cycle, the end of interrupt retires the in-service bit that was highest before the edge, and then the acknowledged vector's bit is set.
- R12: Scalar word 0 reads the 8-bit task priority and word 2 reads the 9-bit spurious register, both written from the low data bits. Unused scalar words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Synchronous initialisation pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address, shared by reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| tprSetEn | input | 1 | Core task-priority load strobe |
| tprSetNibble | input | 4 | Task priority class from the core |
| acceptValid | input | 1 | Incoming vector strobe |
| acceptVector | input | 8 | Incoming vector number |
| acceptLevel | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ackReq | input | 1 | Acknowledge request from the core |
| ackValid | output | 1 | Acknowledge response, one cycle after ackReq |
| ackVector | output | 8 | Vector handed to the core |
| irqOut | output | 1 | Interrupt line to the core |

## Verification
Three pairs of functions can land on the same edge. An accept can meet an acknowledge that clears the same request bit. An end of interrupt can meet an acknowledge that sets an in-service bit. A core task-priority load can meet a register write to the same field. Directed steps drive each pair in one cycle with the vectors lined up, so that the wrong ordering leaves a visibly different map word. A long randomised phase then overlaps all of them freely. After every edge a behavioural model, which applies the clear-before-set and core-before-register rules, is compared with the interrupt line, the acknowledge response and the word being read.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // One-cycle strobes from control to the datapath
  typedef struct packed {
    logic clrAll;       // reset maps and registers to their idle values
    logic reqSet;       // set request bit of the accepted vector
    logic reqLevel;     // trigger bit value for the accepted vector
    logic reqClr;       // clear request bit of the acknowledged vector
    logic isrSet;       // set in-service bit of the acknowledged vector
    logic isrClrTop;    // retire the highest in-service bit
    logic tprFromReg;   // load task priority from register data
    logic tprFromCore;  // load task priority class from the core
    logic svrLoad;      // load spurious register
  } ctrlStrobe_t;

  // Register groups, taken from the top two address bits
  localparam logic [1:0] GRP_SCALAR = 2'd0;
  localparam logic [1:0] GRP_REQ    = 2'd1;
  localparam logic [1:0] GRP_ISR    = 2'd2;
  localparam logic [1:0] GRP_TRIG   = 2'd3;

  // Word numbers inside the scalar group
  localparam int SCL_TPR = 0;
  localparam int SCL_PPR = 1;
  localparam int SCL_SVR = 2;
  localparam int SCL_EOI = 3;

  localparam int CLASS_W = 4;

endpackage

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic [N-1:0]     bits,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // Highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int VEC_W   = 8,
  parameter int WSEL_W  = 3,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       stb,
  input  logic [VEC_W-1:0]  acceptVec,
  input  logic [VEC_W-1:0]  ackVec,
  input  logic [VEC_W-1:0]  tprRegVal,
  input  logic [CLASS_W-1:0] tprNib,
  input  logic [VEC_W:0]    svrVal,
  input  logic [VEC_W-1:0]  pprIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [VEC_W-1:0]  irrTop,
  output logic              irrAny,
  output logic [VEC_W-1:0]  isrTop,
  output logic              isrAny,
  output logic [VEC_W-1:0]  tprQ,
  output logic [VEC_W:0]    svrQ,
  output logic [WORD_W-1:0] rdData
);
  localparam logic [VEC_W:0] SVR_INIT = {1'b0, {VEC_W{1'b1}}};

  logic [NUM_VEC-1:0] irrQ, isrQ, tmrQ;
  logic [NUM_VEC-1:0] irrNext, isrNext, tmrNext;

  irq_prio_find #(.N(NUM_VEC), .IDX_W(VEC_W)) u_findReq (
    .bits(irrQ), .idx(irrTop), .any(irrAny)
  );
  irq_prio_find #(.N(NUM_VEC), .IDX_W(VEC_W)) u_findIsr (
    .bits(isrQ), .idx(isrTop), .any(isrAny)
  );

  // Clear first, then set: a same-cycle set always survives
  always_comb begin
    irrNext = irrQ;
    tmrNext = tmrQ;
    isrNext = isrQ;
    if (stb.reqClr) irrNext[ackVec] = 1'b0;
    if (stb.reqSet) begin
      irrNext[acceptVec] = 1'b1;
      tmrNext[acceptVec] = stb.reqLevel;
    end
    if (stb.isrClrTop && isrAny) isrNext[isrTop] = 1'b0;
    if (stb.isrSet) isrNext[ackVec] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irrQ <= '0;
      isrQ <= '0;
      tmrQ <= '0;
      tprQ <= '0;
      svrQ <= SVR_INIT;
    end else if (stb.clrAll) begin
      irrQ <= '0;
      isrQ <= '0;
      tmrQ <= '0;
      tprQ <= '0;
      svrQ <= SVR_INIT;
    end else begin
      irrQ <= irrNext;
      isrQ <= isrNext;
      tmrQ <= tmrNext;
      if (stb.tprFromCore)
        tprQ <= {tprNib, {(VEC_W-CLASS_W){1'b0}}};
      else if (stb.tprFromReg)
        tprQ <= tprRegVal;
      if (stb.svrLoad) svrQ <= svrVal;
    end
  end

  // Read mux
  logic [1:0]        rdGrp;
  logic [WSEL_W-1:0] rdWord;
  assign rdGrp  = rdAddr[ADDR_W-1 -: 2];
  assign rdWord = rdAddr[WSEL_W-1:0];

  always_comb begin
    rdData = '0;
    case (rdGrp)
      GRP_REQ:  rdData = irrQ[rdWord*WORD_W +: WORD_W];
      GRP_ISR:  rdData = isrQ[rdWord*WORD_W +: WORD_W];
      GRP_TRIG: rdData = tmrQ[rdWord*WORD_W +: WORD_W];
      default: begin
        if (rdWord == WSEL_W'(SCL_TPR))      rdData = WORD_W'(tprQ);
        else if (rdWord == WSEL_W'(SCL_PPR)) rdData = WORD_W'(pprIn);
        else if (rdWord == WSEL_W'(SCL_SVR)) rdData = WORD_W'(svrQ);
      end
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int WSEL_W = 3,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              initReq,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              tprSetEn,
  input  logic              acceptValid,
  input  logic              acceptLevel,
  input  logic              ackReq,
  input  logic [VEC_W-1:0]  irrTop,
  input  logic              irrAny,
  input  logic [VEC_W-1:0]  isrTop,
  input  logic              isrAny,
  input  logic [VEC_W-1:0]  tprQ,
  input  logic [VEC_W:0]    svrQ,
  output ctrlStrobe_t       stb,
  output logic [VEC_W-1:0]  pprOut,
  output logic              irqOut,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVector
);
  logic [CLASS_W-1:0] tprClass, isrClass, irrClass, pprClass;
  logic               suppress, grant;
  logic [VEC_W-1:0]   respVec;
  logic               scalarWr;
  logic [WSEL_W-1:0]  wrWord;

  assign tprClass = tprQ[VEC_W-1 -: CLASS_W];
  assign isrClass = isrTop[VEC_W-1 -: CLASS_W];
  assign irrClass = irrTop[VEC_W-1 -: CLASS_W];

  // Processor priority
  always_comb begin
    if (!isrAny || tprClass >= isrClass) pprOut = tprQ;
    else pprOut = {isrClass, {(VEC_W-CLASS_W){1'b0}}};
  end
  assign pprClass = pprOut[VEC_W-1 -: CLASS_W];

  assign irqOut = svrQ[VEC_W] && irrAny &&
                  ((pprOut == '0) || (irrClass > pprClass));

  // Acknowledge decision
  assign suppress = (tprQ != '0) && (irrTop <= tprQ);
  assign grant    = irrAny && !suppress;
  assign respVec  = grant ? irrTop : svrQ[VEC_W-1:0];

  // Register write decode
  assign scalarWr = regWrEn && (regAddr[ADDR_W-1 -: 2] == GRP_SCALAR);
  assign wrWord   = regAddr[WSEL_W-1:0];

  always_comb begin
    stb             = '0;
    stb.clrAll      = initReq;
    stb.reqSet      = acceptValid;
    stb.reqLevel    = acceptLevel;
    stb.reqClr      = ackReq && irrAny;
    stb.isrSet      = ackReq && grant;
    stb.isrClrTop   = scalarWr && (wrWord == WSEL_W'(SCL_EOI));
    stb.tprFromReg  = scalarWr && (wrWord == WSEL_W'(SCL_TPR));
    stb.tprFromCore = tprSetEn;
    stb.svrLoad     = scalarWr && (wrWord == WSEL_W'(SCL_SVR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
    end else begin
      ackValid  <= ackReq && !initReq;
      if (ackReq) ackVector <= respVec;
    end
  end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   initReq,
  input  logic                                   regWrEn,
  input  logic [$clog2(NUM_VEC/WORD_W)+1:0]      regAddr,
  input  logic [WORD_W-1:0]                      regWrData,
  output logic [WORD_W-1:0]                      regRdData,
  input  logic                                   tprSetEn,
  input  logic [3:0]                             tprSetNibble,
  input  logic                                   acceptValid,
  input  logic [$clog2(NUM_VEC)-1:0]             acceptVector,
  input  logic                                   acceptLevel,
  input  logic                                   ackReq,
  output logic                                   ackValid,
  output logic [$clog2(NUM_VEC)-1:0]             ackVector,
  output logic                                   irqOut
);
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int ADDR_W    = WSEL_W + 2;

  ctrlStrobe_t      stb;
  logic [VEC_W-1:0] irrTop, isrTop, tprQ, pprOut;
  logic             irrAny, isrAny;
  logic [VEC_W:0]   svrQ;

  irq_prio_ctrl #(.VEC_W(VEC_W), .WSEL_W(WSEL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .initReq(initReq),
    .regWrEn(regWrEn), .regAddr(regAddr), .tprSetEn(tprSetEn),
    .acceptValid(acceptValid), .acceptLevel(acceptLevel), .ackReq(ackReq),
    .irrTop(irrTop), .irrAny(irrAny), .isrTop(isrTop), .isrAny(isrAny),
    .tprQ(tprQ), .svrQ(svrQ), .stb(stb), .pprOut(pprOut), .irqOut(irqOut),
    .ackValid(ackValid), .ackVector(ackVector)
  );

  irq_prio_dp #(
    .NUM_VEC(NUM_VEC), .WORD_W(WORD_W), .VEC_W(VEC_W),
    .WSEL_W(WSEL_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .acceptVec(acceptVector), .ackVec(irrTop),
    .tprRegVal(regWrData[VEC_W-1:0]), .tprNib(tprSetNibble),
    .svrVal(regWrData[VEC_W:0]), .pprIn(pprOut), .rdAddr(regAddr),
    .irrTop(irrTop), .irrAny(irrAny), .isrTop(isrTop), .isrAny(isrAny),
    .tprQ(tprQ), .svrQ(svrQ), .rdData(regRdData)
  );
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic initReq,
  input logic ackReq,
  input logic ackValid,
  input logic irqOut,
  input logic svrEn,
  input logic irrAny,
  input logic isrAny,
  input logic eoiStb
);
  // R6
  ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ackReq && !initReq) |=> ackValid);

  // R6
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ackReq |=> !ackValid);

  // R4
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> svrEn);

  // R5
  irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> irrAny);

  // R10
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    initReq |=> (!svrEn && !irrAny && !isrAny && !ackValid));

  // R8
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoiStb && !isrAny && !ackReq && !initReq) |=> !isrAny);
endmodule

bind irq_prio_unit irq_prio_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .initReq(initReq), .ackReq(ackReq),
  .ackValid(ackValid), .irqOut(irqOut), .svrEn(svrQ[VEC_W]),
  .irrAny(irrAny), .isrAny(isrAny), .eoiStb(stb.isrClrTop)
);

// File: tb/irq_prio_unit_tb.sv
`timescale 1ns/1ps
module irq_prio_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        initReq = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        tprSetEn = 1'b0;
  logic [3:0]  tprSetNibble = '0;
  logic        acceptValid = 1'b0;
  logic [7:0]  acceptVector = '0;
  logic        acceptLevel = 1'b0;
  logic        ackReq = 1'b0;
  logic        ackValid;
  logic [7:0]  ackVector;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_unit u_dut (
    .clk(clk), .rst_n(rst_n), .initReq(initReq), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .tprSetEn(tprSetEn), .tprSetNibble(tprSetNibble),
    .acceptValid(acceptValid), .acceptVector(acceptVector),
    .acceptLevel(acceptLevel), .ackReq(ackReq), .ackValid(ackValid),
    .ackVector(ackVector), .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  bit [255:0] mIrr, mIsr, mTmr;
  int mTpr, mSvr, mAckVec;
  bit mAckV;

  function automatic int topBit(bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int modelPpr();
    int e = topBit(mIsr);
    if (e < 0 || (mTpr >> 4) >= (e >> 4)) return mTpr;
    return e & 'hF0;
  endfunction

  function automatic bit modelIrq();
    int h = topBit(mIrr);
    int p = modelPpr();
    if (!mSvr[8] || h < 0) return 1'b0;
    return (p == 0) || ((h >> 4) > (p >> 4));
  endfunction

  function automatic int modelRead(logic [4:0] a);
    int w = a[2:0];
    case (a[4:3])
      2'd1: return int'(mIrr[w*32 +: 32]);
      2'd2: return int'(mIsr[w*32 +: 32]);
      2'd3: return int'(mTmr[w*32 +: 32]);
      default: begin
        if (w == 0) return mTpr;
        if (w == 1) return modelPpr();
        if (w == 2) return mSvr;
        return 0;
      end
    endcase
  endfunction

  function automatic string readTag(logic [4:0] a);
    if (a[4:3] != 2'd0) return "R2";
    if (a[2:0] == 3'd1) return "R7";
    return "R12";
  endfunction

  task automatic modelClear();
    mIrr = '0; mIsr = '0; mTmr = '0;
    mTpr = 0; mSvr = 'hFF; mAckV = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n || initReq) begin
      modelClear();  // R10
    end else begin
      int h, e, v;
      bit setIsr;
      h = topBit(mIrr);
      e = topBit(mIsr);
      setIsr = 1'b0;
      v = mSvr & 'hFF;
      if (ackReq && h >= 0) begin
        mIrr[h] = 1'b0;
        if (!(mTpr != 0 && h <= mTpr)) begin
          v = h;
          setIsr = 1'b1;
        end
      end
      if (regWrEn && regAddr == 5'd3 && e >= 0) mIsr[e] = 1'b0;
      if (setIsr) mIsr[h] = 1'b1;
      if (acceptValid) begin
        mIrr[acceptVector] = 1'b1;
        mTmr[acceptVector] = acceptLevel;
      end
      if (regWrEn && regAddr == 5'd0) mTpr = regWrData & 'hFF;
      if (tprSetEn) mTpr = int'(tprSetNibble) << 4;
      if (regWrEn && regAddr == 5'd2) mSvr = regWrData & 'h1FF;
      mAckV = ackReq;
      if (ackReq) mAckVec = v;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (checking && !done) begin
      int expRd;
      checks++;
      if (irqOut !== modelIrq()) begin
        errors++;
        $display("FAIL R5 irqOut actual=%0b expected=%0b t=%0t", irqOut, modelIrq(), $time);
      end
      checks++;
      if (ackValid !== mAckV) begin
        errors++;
        $display("FAIL R6 ackValid actual=%0b expected=%0b t=%0t", ackValid, mAckV, $time);
      end
      if (mAckV) begin
        checks++;
        if (ackVector !== 8'(mAckVec)) begin
          errors++;
          $display("FAIL R6 ackVector actual=%0h expected=%0h t=%0t", ackVector, mAckVec, $time);
        end
      end
      expRd = modelRead(regAddr);
      checks++;
      if (regRdData !== 32'(expRd)) begin
        errors++;
        $display("FAIL %s read addr=%0h actual=%0h expected=%0h t=%0t",
                 readTag(regAddr), regAddr, regRdData, 32'(expRd), $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic nextCyc();
    @(posedge clk); #5;
    initReq = 0; regWrEn = 0; tprSetEn = 0; acceptValid = 0; ackReq = 0;
  endtask
  task automatic acc(input int v, input bit lvl);
    nextCyc(); acceptValid = 1; acceptVector = 8'(v); acceptLevel = lvl;
  endtask
  task automatic wr(input int a, input int d);
    nextCyc(); regWrEn = 1; regAddr = 5'(a); regWrData = 32'(d);
  endtask
  task automatic ack();
    nextCyc(); ackReq = 1;
  endtask
  task automatic rd(input int a);
    nextCyc(); regAddr = 5'(a);
  endtask
  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    modelClear();
    repeat (3) @(posedge clk);
    checking = 1'b1;         // R10 reset values observed while in reset
    #5 rst_n = 1'b1;
    rd(2); rd(0); rd(8);     // R10 R12 reset readback
    wr(2, 'h1FF);            // R12 enable unit
    acc('h45, 0);            // R1 edge vector
    acc('h80, 1);            // R1 level vector
    rd(8+2); rd(8+4); rd(24+4); rd(24+2);  // R2 word layout
    ack();                   // R3 top vector 0x80 granted
    rd(16+4); rd(1);         // R7 ppr 0x80, R5 irq low
    wr(3, 0);                // R8 retire 0x80
    rd(16+4);
    nextCyc(); tprSetEn = 1; tprSetNibble = 4'h5;  // R9 core load
    rd(0); rd(1);
    ack();                   // R6 suppressed, spurious 0xFF
    wr(2, 'h13F);            // R12 new spurious vector
    acc('h20, 0);
    ack();                   // R6 suppressed, returns 0x3F
    ack();                   // R6 empty, returns 0x3F
    // R9 core load and register write in one cycle
    nextCyc(); tprSetEn = 1; tprSetNibble = 4'h2;
    regWrEn = 1; regAddr = 5'd0; regWrData = 'h77;
    rd(0);
    wr(0, 0);
    wr(3, 0); rd(16+0);      // R8 end of interrupt with nothing in service
    // R11 accept and acknowledge on the same vector
    acc('hA0, 1);
    nextCyc(); ackReq = 1; acceptValid = 1; acceptVector = 8'hA0; acceptLevel = 0;
    rd(8+5); rd(16+5); rd(24+5);
    // R11 end of interrupt and acknowledge together
    nextCyc(); ackReq = 1; regWrEn = 1; regAddr = 5'd3;
    rd(16+5); rd(1);
    wr(2, 'h0FF);            // R4 software disable
    acc('hF0, 0); rd(8+7);
    wr(2, 'h1FF);
    nextCyc(); initReq = 1; acceptValid = 1; acceptVector = 8'h33; // R10
    rd(8+1); rd(2);
    wr(2, 'h1FF);
    // R3 R5 R7 mixed traffic
    for (int i = 0; i < 1500; i++) begin
      int r;
      nextCyc();
      r = $urandom_range(99);
      if ($urandom_range(1)) begin
        acceptValid = 1;
        acceptVector = 8'($urandom_range(255));
        acceptLevel = 1'($urandom_range(1));
      end
      ackReq = ($urandom_range(9) < 3);
      if (r < 15) begin regWrEn = 1; regAddr = 5'd3; end
      else if (r < 18) begin regWrEn = 1; regAddr = 5'd2; regWrData = 32'($urandom_range(511) | 'h100); end
      else if (r < 20) begin regWrEn = 1; regAddr = 5'd0; regWrData = 32'($urandom_range(255)); end
      else if (r < 21) begin regWrEn = 1; regAddr = 5'd2; regWrData = 32'($urandom_range(255)); end
      else begin regAddr = 5'($urandom_range(31)); end
      if (r > 95) begin tprSetEn = 1; tprSetNibble = 4'($urandom_range(15)); end
      if (r == 50 && i > 700) initReq = 1;
    end
    nextCyc();
    nextCyc();
    @(negedge clk); #1;
    finishRun();
  end
endmodule